// File: doc/BRIEF.md
# Timestamped Packet Lateness Checker

This block decides, for every source packet handed to it, whether the packet's timestamp is still reachable against a free-running cycle timer. Both the timestamp and the timer value are in mixed radix. A coarse cycle count wraps at 8000. A fine offset, counted on the 24.576 MHz clock, wraps at 3072 and carries into the cycle count. The block computes the timestamp minus the timer value and compares the result against a programmable window.

The block has two modes. In transmit mode an on-time packet is passed straight on. In receive mode an on-time packet is parked in a single holding slot and released when the timer reaches its timestamp. In either mode a late packet is discarded with a mode-specific lateness pulse. Payload storage, header parsing and the timer itself are outside the block. Each packet is identified only by a tag, which travels to the output.

Top module: `lpc_checker`

## Requirements
- R1: The 16-bit window register resets to 0x0000 and reads back what was last written. Bits 15..8 hold the coarse limit in whole cycles. Bits 7..0 hold the fine limit in units of 16 offset ticks (the byte is shifted left by 4).
- R2: The difference is taken in mixed radix. When the offset difference is negative, 3072 is added to it and one is borrowed from the cycle difference. The cycle difference wraps modulo 8000.
- R3: A packet is on time when the difference, expressed as ticks (cycles×3072 + offset), is at most coarse×3072 + fine×16. This holds even when the fine limit reaches a whole cycle (fine byte 0xC0).
- R4: A difference whose cycle part is 4000 or more after wrapping counts as negative, and the packet is late.
- R5: In transmit mode, an on-time packet raises `out_valid` with its tag in the cycle after it is accepted.
- R6: In transmit mode, a late packet raises `drop` and `late_tx` together for one cycle, with its tag, in the cycle after it is accepted.
- R7: In receive mode, a late packet raises `drop` and `late_rx` together for one cycle, with its tag, in the cycle after it is accepted.
- R8: In receive mode, an on-time packet with a non-zero difference sets `busy` and holds `pkt_ready` low. In the cycle after the timer equals the timestamp, `busy` clears and `out_valid` is raised with the held tag. No packet is accepted while `busy` is high.
- R9: Every accepted packet yields exactly one decision: a pass, a drop, or a hold. No output pulse appears without an accepted packet or a release, and every pulse lasts a single cycle.
- R10: In receive mode, a packet whose difference is exactly zero is released in the cycle after it is accepted, without setting `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rx | input | 1 | 1 = receive mode, 0 = transmit mode |
| win_we | input | 1 | Window register write strobe |
| win_wdata | input | 16 | Window register write data |
| win_rdata | output | 16 | Window register read data |
| tmr_cycle | input | 13 | Current timer cycle count (0..7999) |
| tmr_offset | input | 12 | Current timer fine offset (0..3071) |
| pkt_valid | input | 1 | Packet presented |
| pkt_ready | output | 1 | Packet can be accepted |
| pkt_cycle | input | 13 | Timestamp cycle count |
| pkt_offset | input | 12 | Timestamp fine offset |
| pkt_tag | input | 8 | Packet identifier |
| out_valid | output | 1 | Packet passed or released (one cycle) |
| out_tag | output | 8 | Tag of the packet passed, released or dropped |
| drop | output | 1 | Packet discarded (one cycle) |
| late_tx | output | 1 | Transmit lateness report |
| late_rx | output | 1 | Receive lateness report |
| busy | output | 1 | Receive holding slot occupied |

## Verification
The assertions assume that `mode_rx` changes only while no packet is held and no decision is in flight. They also assume that the timer advances by at most one tick per clock, so a held timestamp is never stepped over. The bench changes mode only between idle phases. It moves the timer either by explicit setting while nothing is held, or by single-tick steps while waiting for a release. It keeps `pkt_valid` low during reset.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    // Outcome of one lateness decision for an accepted packet.
    typedef enum logic [1:0] {
        DEC_PASS = 2'd0,
        DEC_HOLD = 2'd1,
        DEC_LATE = 2'd2
    } dec_e;
endpackage

// File: rtl/lpc_window_reg.sv
// Window register: holds the programmed lateness window.
// Assumes: writes take effect on the next clock, no byte enables.
module lpc_window_reg #(
    parameter int unsigned WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIN_W-1:0] wdata,
    output logic [WIN_W-1:0] q
);
    // Capture write data; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/lpc_ts_diff.sv
// Mixed-radix timestamp difference and window comparison (combinational).
// Assumes: offsets lie in 0..OFF_MOD-1 and cycles in 0..CYC_MOD-1.
// The fine half of the window is scaled by 2**FINE_SHIFT and normalised
// into cycles so that a fine limit of one whole cycle compares correctly.
module lpc_ts_diff #(
    parameter int unsigned CYC_W      = 13,
    parameter int unsigned OFF_W      = 12,
    parameter int unsigned CYC_MOD    = 8000,
    parameter int unsigned OFF_MOD    = 3072,
    parameter int unsigned WIN_W      = 16,
    parameter int unsigned FINE_SHIFT = 4
) (
    input  logic [CYC_W-1:0] ts_cyc,
    input  logic [OFF_W-1:0] ts_off,
    input  logic [CYC_W-1:0] tm_cyc,
    input  logic [OFF_W-1:0] tm_off,
    input  logic [WIN_W-1:0] win,
    output logic             on_time,
    output logic             at_time
);
    localparam int unsigned HALF_W = WIN_W / 2;
    localparam int unsigned FINE_W = HALF_W + FINE_SHIFT;
    localparam int unsigned HALF   = CYC_MOD / 2;

    logic [OFF_W:0]   off_raw;
    logic             borrow;
    logic [OFF_W-1:0] off_d;
    logic [CYC_W:0]   cyc_sum;
    logic [CYC_W-1:0] cyc_d;
    logic [FINE_W-1:0] fine_ext;
    logic [31:0]      lim_cyc, lim_off, cyc_c, off_c;
    logic             negative;

    // Subtract offsets with borrow, then cycles modulo CYC_MOD.
    always_comb begin
        off_raw = {1'b0, ts_off} - {1'b0, tm_off};
        borrow  = off_raw[OFF_W];
        off_d   = borrow ? OFF_W'(off_raw + (OFF_W+1)'(OFF_MOD)) : off_raw[OFF_W-1:0];
        cyc_sum = {1'b0, ts_cyc} + (CYC_W+1)'(CYC_MOD) - {1'b0, tm_cyc} - (CYC_W+1)'(borrow);
        cyc_d   = (cyc_sum >= (CYC_W+1)'(CYC_MOD)) ? CYC_W'(cyc_sum - (CYC_W+1)'(CYC_MOD))
                                                 : cyc_sum[CYC_W-1:0];
    end

    // Normalise the scaled fine limit into a mixed-radix limit and compare.
    always_comb begin
        fine_ext = {win[HALF_W-1:0], FINE_SHIFT'(0)};
        lim_cyc  = 32'(win[WIN_W-1:HALF_W]);
        lim_off  = 32'(fine_ext);
        if (lim_off >= OFF_MOD) begin
            lim_cyc = lim_cyc + 32'd1;
            lim_off = lim_off - OFF_MOD;
        end
        cyc_c    = 32'(cyc_d);
        off_c    = 32'(off_d);
        negative = (cyc_c >= HALF);
        on_time  = !negative &&
                   ((cyc_c < lim_cyc) || ((cyc_c == lim_cyc) && (off_c <= lim_off)));
        at_time  = (cyc_d == '0) && (off_d == '0);
    end
endmodule

// File: rtl/lpc_rx_hold.sv
// Receive holding slot: parks one packet until the timer reaches its
// timestamp. Assumes the timer steps by at most one tick per clock.
module lpc_rx_hold #(
    parameter int unsigned CYC_W = 13,
    parameter int unsigned OFF_W = 12,
    parameter int unsigned TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CYC_W-1:0] ld_cyc,
    input  logic [OFF_W-1:0] ld_off,
    input  logic [TAG_W-1:0] ld_tag,
    input  logic [CYC_W-1:0] tm_cyc,
    input  logic [OFF_W-1:0] tm_off,
    output logic             busy,
    output logic             release_now,
    output logic [TAG_W-1:0] held_tag
);
    logic [CYC_W-1:0] held_cyc;
    logic [OFF_W-1:0] held_off;

    // Release when the timer matches the parked timestamp.
    assign release_now = busy && (tm_cyc == held_cyc) && (tm_off == held_off);

    // Slot occupancy and stored timestamp/tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            held_cyc <= '0;
            held_off <= '0;
            held_tag <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            held_cyc <= ld_cyc;
            held_off <= ld_off;
            held_tag <= ld_tag;
        end else if (release_now) begin
            busy     <= 1'b0;
        end
    end
endmodule

// File: rtl/lpc_checker.sv
// Top: accepts packets, classifies each against the window and either
// passes, parks (receive mode) or drops it with a lateness pulse.
// Assumes mode_rx is changed only while idle.
module lpc_checker
    import lpc_pkg::*;
#(
    parameter int unsigned CYC_W      = 13,
    parameter int unsigned OFF_W      = 12,
    parameter int unsigned CYC_MOD    = 8000,
    parameter int unsigned OFF_MOD    = 3072,
    parameter int unsigned WIN_W      = 16,
    parameter int unsigned FINE_SHIFT = 4,
    parameter int unsigned TAG_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_rx,
    input  logic             win_we,
    input  logic [WIN_W-1:0] win_wdata,
    output logic [WIN_W-1:0] win_rdata,
    input  logic [CYC_W-1:0] tmr_cycle,
    input  logic [OFF_W-1:0] tmr_offset,
    input  logic             pkt_valid,
    output logic             pkt_ready,
    input  logic [CYC_W-1:0] pkt_cycle,
    input  logic [OFF_W-1:0] pkt_offset,
    input  logic [TAG_W-1:0] pkt_tag,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic             drop,
    output logic             late_tx,
    output logic             late_rx,
    output logic             busy
);
    logic             on_time, at_time, accept, release_now, load;
    logic [TAG_W-1:0] held_tag;
    dec_e             dec;

    lpc_window_reg #(.WIN_W(WIN_W)) u_win (
        .clk(clk), .rst_n(rst_n), .we(win_we), .wdata(win_wdata), .q(win_rdata)
    );

    lpc_ts_diff #(
        .CYC_W(CYC_W), .OFF_W(OFF_W), .CYC_MOD(CYC_MOD), .OFF_MOD(OFF_MOD),
        .WIN_W(WIN_W), .FINE_SHIFT(FINE_SHIFT)
    ) u_diff (
        .ts_cyc(pkt_cycle), .ts_off(pkt_offset),
        .tm_cyc(tmr_cycle), .tm_off(tmr_offset),
        .win(win_rdata), .on_time(on_time), .at_time(at_time)
    );

    lpc_rx_hold #(.CYC_W(CYC_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(load),
        .ld_cyc(pkt_cycle), .ld_off(pkt_offset), .ld_tag(pkt_tag),
        .tm_cyc(tmr_cycle), .tm_off(tmr_offset),
        .busy(busy), .release_now(release_now), .held_tag(held_tag)
    );

    // Accept only while the holding slot is free.
    assign pkt_ready = !busy;
    assign accept    = pkt_valid && pkt_ready;

    // Classify the presented packet.
    always_comb begin
        if (!on_time)                dec = DEC_LATE;
        else if (mode_rx && !at_time) dec = DEC_HOLD;
        else                         dec = DEC_PASS;
    end

    assign load = accept && (dec == DEC_HOLD);

    // Register single-cycle result pulses and the associated tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            drop      <= 1'b0;
            late_tx   <= 1'b0;
            late_rx   <= 1'b0;
            out_tag   <= '0;
        end else begin
            out_valid <= 1'b0;
            drop      <= 1'b0;
            late_tx   <= 1'b0;
            late_rx   <= 1'b0;
            if (accept) begin
                case (dec)
                    DEC_PASS: begin
                        out_valid <= 1'b1;
                        out_tag   <= pkt_tag;
                    end
                    DEC_LATE: begin
                        drop    <= 1'b1;
                        late_tx <= !mode_rx;
                        late_rx <= mode_rx;
                        out_tag <= pkt_tag;
                    end
                    default: ;
                endcase
            end else if (release_now) begin
                out_valid <= 1'b1;
                out_tag   <= held_tag;
            end
        end
    end
endmodule

// File: rtl/lpc_checker_sva.sv
// Property checker for lpc_checker, attached by bind.
module lpc_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic mode_rx,
    input logic pkt_valid,
    input logic pkt_ready,
    input logic out_valid,
    input logic drop,
    input logic late_tx,
    input logic late_rx,
    input logic busy
);
    logic accept;
    assign accept = pkt_valid && pkt_ready;

    assert_late_tx_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        late_tx |-> (drop && !late_rx && !out_valid));

    assert_late_tx_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        late_tx |-> !$past(mode_rx));

    assert_late_rx_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        late_rx |-> (drop && !late_tx && !out_valid));

    assert_late_rx_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        late_rx |-> $past(mode_rx));

    assert_busy_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pkt_ready);

    assert_release_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> out_valid);

    assert_one_decision_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> $onehot({out_valid, drop, busy}));

    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || drop) |-> ($past(accept) || $fell(busy)));

    assert_drop_reason_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drop |-> (late_tx || late_rx));
endmodule

bind lpc_checker lpc_checker_sva u_sva (
    .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .out_valid(out_valid), .drop(drop),
    .late_tx(late_tx), .late_rx(late_rx), .busy(busy)
);

// File: tb/tb_lpc_checker.sv
module tb_lpc_checker;
    localparam int CMOD  = 8000;
    localparam int OMOD  = 3072;
    localparam int TOTAL = CMOD * OMOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_rx = 1'b0;
    logic        win_we = 1'b0;
    logic [15:0] win_wdata = '0;
    logic [15:0] win_rdata;
    logic [12:0] tm_cyc = '0;
    logic [11:0] tm_off = '0;
    logic        pkt_valid = 1'b0;
    logic        pkt_ready;
    logic [12:0] pkt_cycle = '0;
    logic [11:0] pkt_offset = '0;
    logic [7:0]  pkt_tag = '0;
    logic        out_valid, drop, late_tx, late_rx, busy;
    logic [7:0]  out_tag;

    lpc_checker dut (
        .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx),
        .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .tmr_cycle(tm_cyc), .tmr_offset(tm_off),
        .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
        .pkt_cycle(pkt_cycle), .pkt_offset(pkt_offset), .pkt_tag(pkt_tag),
        .out_valid(out_valid), .out_tag(out_tag), .drop(drop),
        .late_tx(late_tx), .late_rx(late_rx), .busy(busy)
    );

    always #4 clk = ~clk;

    // Scoreboard item: kind 0 = pass, 1 = transmit drop, 2 = receive drop.
    typedef struct {
        int         kind;
        logic [7:0] tag;
        string      req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    int   win_model = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic bit model_on_time(input int tc, input int to,
                                         input int mc, input int mo);
        int d;
        d = ((tc * OMOD + to) - (mc * OMOD + mo) + TOTAL) % TOTAL;
        if (d >= TOTAL / 2) return 1'b0;
        return d <= ((win_model >> 8) * OMOD + (win_model & 255) * 16);
    endfunction

    task automatic wr_win(input logic [15:0] v);
        @(negedge clk);
        win_we = 1'b1; win_wdata = v;
        @(negedge clk);
        win_we = 1'b0;
        win_model = int'(v);
        chk(win_rdata == v, "R1", "window readback", int'(win_rdata), int'(v));
    endtask

    task automatic set_tm(input int c, input int o);
        @(negedge clk);
        tm_cyc = 13'(c); tm_off = 12'(o);
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tm_off == 12'(OMOD - 1)) begin
                tm_off = '0;
                tm_cyc = (tm_cyc == 13'(CMOD - 1)) ? '0 : tm_cyc + 13'd1;
            end else begin
                tm_off = tm_off + 12'd1;
            end
        end
    endtask

    // Driver: present one packet and push the expected outcome.
    task automatic send(input int c, input int o, input logic [7:0] tag,
                        input string req);
        exp_t e;
        @(negedge clk);
        chk(pkt_ready == 1'b1, req, "ready before send", int'(pkt_ready), 1);
        e.tag = tag;
        e.req = req;
        if (model_on_time(c, o, int'(tm_cyc), int'(tm_off))) e.kind = 0;
        else e.kind = mode_rx ? 2 : 1;
        sb.push_back(e);
        pkt_valid = 1'b1; pkt_cycle = 13'(c); pkt_offset = 12'(o); pkt_tag = tag;
        @(negedge clk);
        pkt_valid = 1'b0;
    endtask

    // Monitor: pop and compare each output event.
    always @(posedge clk) begin
        #1;
        if (rst_n && (out_valid || drop)) begin
            int act;
            if (out_valid && !drop && !late_tx && !late_rx) act = 0;
            else if (drop && late_tx && !late_rx && !out_valid) act = 1;
            else if (drop && late_rx && !late_tx && !out_valid) act = 2;
            else act = 3;
            if (sb.size() == 0) begin
                chk(1'b0, "R9", "unexpected output event", act, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(act == e.kind, e.req, "decision kind", act, e.kind);
                chk(out_tag == e.tag, e.req, "tag", int'(out_tag), int'(e.tag));
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(win_rdata == 16'h0000, "R1", "window after reset", int'(win_rdata), 0);
        chk(pkt_ready == 1'b1, "R8", "ready after reset", int'(pkt_ready), 1);
        chk(busy == 1'b0, "R8", "busy after reset", int'(busy), 0);
        chk(!out_valid && !drop && !late_tx && !late_rx, "R9", "pulses after reset",
            int'({out_valid, drop, late_tx, late_rx}), 0);

        // Transmit mode, window 3 cycles + 1024 ticks.
        wr_win(16'h0340);
        set_tm(100, 0);
        send(100, 5, 8'h01, "R5");
        send(100, 0, 8'h02, "R5");
        send(103, 1024, 8'h03, "R3");
        send(103, 1025, 8'h04, "R6");
        send(99, 3071, 8'h05, "R4");
        set_tm(100, 100);
        send(101, 50, 8'h06, "R2");
        send(103, 1124, 8'h07, "R3");
        send(103, 1125, 8'h08, "R6");
        set_tm(7999, 3000);
        send(0, 10, 8'h09, "R2");
        send(3999, 3000, 8'h0A, "R4");

        // Fine limit of a whole cycle: window 2 cycles + 0xC0*16.
        wr_win(16'h02C0);
        set_tm(10, 0);
        send(13, 0, 8'h0B, "R3");
        send(13, 1, 8'h0C, "R3");
        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R5", "transmit results drained", sb.size(), 0);

        // Receive mode.
        mode_rx = 1'b1;
        wr_win(16'h0500);
        set_tm(200, 0);
        send(200, 0, 8'h20, "R10");
        chk(busy == 1'b0, "R10", "no hold on zero difference", int'(busy), 0);
        chk(sb.size() == 0, "R10", "zero difference released", sb.size(), 0);

        send(200, 30, 8'h21, "R8");
        chk(busy == 1'b1, "R8", "busy while held", int'(busy), 1);
        chk(pkt_ready == 1'b0, "R8", "ready low while held", int'(pkt_ready), 0);
        tick_n(29);
        chk(sb.size() == 1, "R8", "not released early", sb.size(), 1);
        tick_n(1);
        @(negedge clk);
        chk(sb.size() == 0, "R8", "released at timestamp", sb.size(), 0);
        chk(busy == 1'b0, "R8", "busy cleared", int'(busy), 0);

        // Hold across an offset wrap; a second packet must be refused.
        set_tm(300, 3070);
        send(301, 2, 8'h22, "R2");
        @(negedge clk);
        pkt_valid = 1'b1; pkt_cycle = 13'd301; pkt_offset = 12'd1; pkt_tag = 8'h99;
        @(negedge clk);
        chk(pkt_ready == 1'b0, "R8", "refuse while busy", int'(pkt_ready), 0);
        pkt_valid = 1'b0;
        tick_n(4);
        @(negedge clk);
        chk(sb.size() == 0, "R2", "release after borrow", sb.size(), 0);
        chk(busy == 1'b0, "R8", "slot free again", int'(busy), 0);

        send(301, 1, 8'h23, "R7");
        send(310, 0, 8'h24, "R7");
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R9", "all decisions seen", sb.size(), 0);
        chk(busy == 1'b0, "R7", "late packet not held", int'(busy), 0);
        finish_run();
    end
endmodule